// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by fetching two table entries from memory, one at a time, through a single-word read port. A requester hands over one address and a master tag using a valid/ready handshake. The walker computes the address of the directory entry from a table base input and reads that entry. If the entry is usable, the walker reads the page entry that it points to. It then returns the physical address together with the four-bit authority index stored in the page entry. Only one translation is in flight at a time. A new request is accepted only after the previous result has been taken.

When a table entry is missing, the walker returns a fault instead of a translation. The fault code shows which level failed, and the result still carries the faulting virtual address and the master tag, so a fault handler can report it. When translation is disabled, a request is answered straight away with the physical address equal to the virtual address. No memory access and no fault take place in that case.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `xl_valid` and `mem_rd_valid` are 0.
- R2: Once a request is accepted, `req_ready` stays 0 until the result is taken with `xl_valid && xl_ready`. No memory read is issued while a result is pending.
- R3: The first read goes to `tbl_base + 4 * va[31:20]`, with 32-bit wrap-around. `tbl_base` is sampled when the request is accepted.
- R4: A directory entry is usable only when its bits 1:0 are exactly `01`. Any other value ends the walk after one read, with `xl_fault = 01` (first-level fault).
- R5: For a usable directory entry `d`, the second read goes to `{d[31:10], 10'b0} + 4 * va[19:12]`.
- R6: A page entry is usable only when its bit 1 is set. Otherwise the walk ends after two reads, with `xl_fault = 10` (second-level fault). The fault code is never `11`.
- R7: On success, `xl_fault = 00`, `xl_pa = {p[31:12], va[11:0]}`, `xl_aci = p[7:4]`, and `xl_pte = p`, where `p` is the page entry.
- R8: Every result echoes the accepted virtual address on `xl_va` and the master tag on `xl_mid`. On a fault, `xl_pa`, `xl_pte` and `xl_aci` are all 0.
- R9: If `en` is 0 when a request is accepted, the result has `xl_pa = va`, `xl_fault = 00`, `xl_pte = 0` and `xl_aci = 0`, and no memory read is made.
- R10: A pending memory read keeps `mem_rd_valid` high and `mem_rd_addr` stable until `mem_rd_ready` is high. A pending result keeps `xl_valid` high and its fields stable until `xl_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Translation enable, sampled when a request is accepted |
| tbl_base | input | 32 | Directory base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_mid | input | MID_W | Requesting master tag |
| mem_rd_valid | output | 1 | Memory word read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| xl_valid | output | 1 | Result valid |
| xl_ready | input | 1 | Result taken |
| xl_pa | output | 32 | Physical address |
| xl_aci | output | 4 | Authority index from the page entry |
| xl_pte | output | 32 | Raw page entry, 0 on fault or bypass |
| xl_fault | output | 2 | 00 none, 01 first-level, 10 second-level |
| xl_va | output | 32 | Echoed virtual address |
| xl_mid | output | MID_W | Echoed master tag |

## Verification
The bench builds the walker with its default master tag width of 4, so that random requests cover all sixteen tags. Because the address split is fixed, random virtual addresses reach every directory index and every page index. That includes the last directory entry, where a base near the top of memory makes the entry address wrap. A bench memory model with random accept and response delays exercises the stall paths of both handshakes. Directed entries probe each non-`01` directory attribute value and a page entry that is invalid but has every other bit set.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int MID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [31:0]      tbl_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_va,
  input  logic [MID_W-1:0] req_mid,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [31:0]      mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             xl_valid,
  input  logic             xl_ready,
  output logic [31:0]      xl_pa,
  output logic [3:0]       xl_aci,
  output logic [31:0]      xl_pte,
  output logic [1:0]       xl_fault,
  output logic [31:0]      xl_va,
  output logic [MID_W-1:0] xl_mid
);
  localparam int OFF_W   = 12;
  localparam int PG_W    = 8;
  localparam int DIR_W   = 32 - OFF_W - PG_W;
  localparam int ENT_SH  = 2;
  localparam int PTB_LSB = 10;
  localparam logic [1:0] FLT_NONE = 2'b00;
  localparam logic [1:0] FLT_DIR  = 2'b01;
  localparam logic [1:0] FLT_PG   = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_RD_DIR, S_WT_DIR, S_RD_PG, S_WT_PG, S_DONE, S_FLT} st_t;
  st_t st;

  logic [31:0]      va_q, addr_q, pte_q;
  logic [MID_W-1:0] mid_q;
  logic [1:0]       flt_q;
  logic             pass_q;

  logic [31:0] dir_off, pg_off;
  assign dir_off = {{(32-DIR_W-ENT_SH){1'b0}}, req_va[31 -: DIR_W], {ENT_SH{1'b0}}};
  assign pg_off  = {{(32-PG_W-ENT_SH){1'b0}}, va_q[OFF_W +: PG_W], {ENT_SH{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      pte_q  <= '0;
      mid_q  <= '0;
      flt_q  <= FLT_NONE;
      pass_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          mid_q  <= req_mid;
          pte_q  <= '0;
          flt_q  <= FLT_NONE;
          pass_q <= !en;
          addr_q <= tbl_base + dir_off;
          st     <= en ? S_RD_DIR : S_DONE;
        end
        S_RD_DIR: if (mem_rd_ready) st <= S_WT_DIR;
        S_WT_DIR: if (mem_rsp_valid) begin
          if (mem_rsp_data[1:0] == 2'b01) begin
            addr_q <= {mem_rsp_data[31:PTB_LSB], {PTB_LSB{1'b0}}} + pg_off;
            st     <= S_RD_PG;
          end else begin
            flt_q <= FLT_DIR;
            st    <= S_FLT;
          end
        end
        S_RD_PG: if (mem_rd_ready) st <= S_WT_PG;
        S_WT_PG: if (mem_rsp_valid) begin
          if (mem_rsp_data[1]) begin
            pte_q <= mem_rsp_data;
            st    <= S_DONE;
          end else begin
            flt_q <= FLT_PG;
            st    <= S_FLT;
          end
        end
        S_DONE, S_FLT: if (xl_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE);
  assign mem_rd_valid = (st == S_RD_DIR) || (st == S_RD_PG);
  assign mem_rd_addr  = addr_q;
  assign xl_valid     = (st == S_DONE) || (st == S_FLT);
  assign xl_pa        = (st == S_FLT) ? 32'd0 :
                        pass_q ? va_q : {pte_q[31:OFF_W], va_q[OFF_W-1:0]};
  assign xl_aci       = pte_q[7:4];
  assign xl_pte       = pte_q;
  assign xl_fault     = flt_q;
  assign xl_va        = va_q;
  assign xl_mid       = mid_q;

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> (!req_ready && !mem_rd_valid));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !xl_ready) |=> (xl_valid && $stable(xl_pa) && $stable(xl_fault) && $stable(xl_va)));

  assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_fault != FLT_NONE) |-> (xl_pa == 32'd0 && xl_pte == 32'd0));

  assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> $onehot0(xl_fault));

  assert_pte_usable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_fault == FLT_NONE && xl_pte != 32'd0) |-> xl_pte[1]);
endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  localparam int MID_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, en, req_valid, req_ready;
  logic [31:0]      tbl_base, req_va;
  logic [MID_W-1:0] req_mid;
  logic             mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [31:0]      mem_rd_addr, mem_rsp_data;
  logic             xl_valid, xl_ready;
  logic [31:0]      xl_pa, xl_pte, xl_va;
  logic [3:0]       xl_aci;
  logic [1:0]       xl_fault;
  logic [MID_W-1:0] xl_mid;

  ptw_walker #(.MID_W(MID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_mid(req_mid),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_pa(xl_pa), .xl_aci(xl_aci),
    .xl_pte(xl_pte), .xl_fault(xl_fault), .xl_va(xl_va), .xl_mid(xl_mid)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] o_a0, o_d0, o_a1, o_d1, salt;
  bit o_en0, o_en1;
  int n_rd;
  logic [31:0] rd_addr [2];
  logic [31:0] ma;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (o_en0 && a == o_a0) return o_d0;
    if (o_en1 && a == o_a1) return o_d1;
    return (a * 32'h9E3779B1) ^ salt ^ (a >> 7);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; n_rd = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid && ($urandom % 3) != 0) begin
        mem_rd_ready = 1'b1;
        ma = mem_rd_addr;
        if (n_rd < 2) rd_addr[n_rd] = ma;
        n_rd++;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(ma);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic xlat(input logic [31:0] va, input logic [MID_W-1:0] mid, input bit e, input logic [31:0] base);
    logic [31:0] a0, a1, d, p, exp_pa, exp_pte, hold_pa;
    logic [1:0]  kind;
    int          reads;
    string       tg;
    a0 = base + {18'd0, va[31:20], 2'b00};
    a1 = '0; exp_pa = '0; exp_pte = '0; kind = 2'b00; reads = 0;
    if (!e) begin
      exp_pa = va;
    end else begin
      d = mem_word(a0); reads = 1;
      if (d[1:0] != 2'b01) kind = 2'b01;
      else begin
        a1 = {d[31:10], 10'd0} + {22'd0, va[19:12], 2'b00};
        p = mem_word(a1); reads = 2;
        if (!p[1]) kind = 2'b10;
        else begin
          exp_pa = {p[31:12], va[11:0]};
          exp_pte = p;
        end
      end
    end
    tg = !e ? "R9" : (kind == 2'b01) ? "R4" : (kind == 2'b10) ? "R6" : "R7";

    @(negedge clk);
    n_rd = 0; en = e; tbl_base = base; req_va = va; req_mid = mid; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_va = ~va; tbl_base = ~base;
    chk("R2", "ready after accept", {31'd0, req_ready}, 32'd0);
    while (!xl_valid) @(negedge clk);
    hold_pa = xl_pa;
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk("R10", "result held", {31'd0, xl_valid}, 32'd1);
      chk("R10", "pa stable", xl_pa, hold_pa);
      chk("R2", "no accept while pending", {31'd0, req_ready}, 32'd0);
    end
    chk(tg, "fault code", {30'd0, xl_fault}, {30'd0, kind});
    chk(tg, "pa", xl_pa, exp_pa);
    chk(tg, "pte", xl_pte, exp_pte);
    chk(kind != 0 ? "R8" : tg, "aci", {28'd0, xl_aci}, {28'd0, exp_pte[7:4]});
    chk("R8", "va echo", xl_va, va);
    chk("R8", "mid echo", {28'd0, xl_mid}, {28'd0, mid});
    chk(!e ? "R9" : "R4", "read count", n_rd, reads);
    if (reads >= 1) chk("R3", "dir entry addr", rd_addr[0], a0);
    if (reads >= 2) chk("R5", "page entry addr", rd_addr[1], a1);
    xl_ready = 1'b1;
    @(negedge clk);
    xl_ready = 1'b0;
    chk("R2", "ready after take", {30'd0, xl_valid, req_ready}, 32'd1);
  endtask

  task automatic directed(input logic [31:0] va, input logic [31:0] base, input logic [31:0] d0,
                          input logic [31:0] d1, input bit e);
    o_a0 = base + {18'd0, va[31:20], 2'b00};
    o_d0 = d0;
    o_a1 = {d0[31:10], 10'd0} + {22'd0, va[19:12], 2'b00};
    o_d1 = d1;
    o_en0 = 1'b1; o_en1 = 1'b1;
    xlat(va, 4'd5, e, base);
    o_en0 = 1'b0; o_en1 = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    salt = 32'h5A5A_1234; o_en0 = 0; o_en1 = 0;
    o_a0 = '0; o_a1 = '0; o_d0 = '0; o_d1 = '0;
    rst_n = 1'b0; en = 1'b1; tbl_base = '0; req_valid = 1'b0; req_va = '0; req_mid = '0;
    xl_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "reset result valid", {31'd0, xl_valid}, 32'd0);
    chk("R1", "reset mem valid", {31'd0, mem_rd_valid}, 32'd0);
    rst_n = 1'b1;

    directed(32'h1234_5678, 32'h0001_0000, 32'h0ABC_D401, 32'h8765_40A2, 1'b1); // R7 success
    directed(32'h1234_5678, 32'h0001_0000, 32'h0ABC_D403, 32'h8765_40A2, 1'b1); // R4 attr 11
    directed(32'h1234_5678, 32'h0001_0000, 32'h0ABC_D400, 32'h8765_40A2, 1'b1); // R4 attr 00
    directed(32'h1234_5678, 32'h0001_0000, 32'h0ABC_D402, 32'h8765_40A2, 1'b1); // R4 attr 10
    directed(32'hABCD_EF01, 32'h0002_0000, 32'h0030_0001, 32'hFFFF_FFFD, 1'b1); // R6 invalid page
    directed(32'hDEAD_BEEF, 32'h0001_0000, 32'h0ABC_D401, 32'h8765_40A2, 1'b0); // R9 bypass
    directed(32'hFFFF_FFFF, 32'hFFFF_F000, 32'hFFFF_FC01, 32'h1234_5FF2, 1'b1); // R3 wrap, R5 top index

    for (int i = 0; i < 400; i++) begin
      salt = $urandom;
      xlat($urandom, 4'($urandom), ($urandom % 10) != 0, $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule